// File: doc/BRIEF.md
# Paged Memory Access Permission Checker

This block sits between a processor bus and the memory system and rules on each access, one per cycle. It looks at the address, the direction, the processor mode and a translation strobe, and it returns either a grant with the address memory should see, or an abort. The low half of the address space (below 0x2000000) is logically mapped RAM. A 128-entry page table maps pages of 32 KB onto physical pages there. Each entry carries a valid bit, a physical page number and a 2-bit protection level. Above that region the address passes through unchanged, subject only to the mode-based region rules.

The translation strobe is derived inside the block. It is high for every user-mode access, and also for a privileged single transfer that is post-indexed with write-back requested. Protection levels are enforced only while the strobe is high. An OS-mode input relaxes some of the levels. Block (multiple-register) transfers are framed by a small state machine with two states. `ST_IDLE` moves to `ST_BLOCK` on a non-final beat (transition T_OPEN). `ST_BLOCK` returns to `ST_IDLE` on the final beat (T_CLOSE). A final beat seen in `ST_IDLE` is a one-beat block, and the machine stays in `ST_IDLE`. A non-final beat in `ST_BLOCK` also keeps the state. A sticky flag collects rejected beats, and their abort is raised once, on the final beat.

Top module: `mpc_top`

## Requirements
- R1: After reset, rsp_valid and rsp_abort are 0 and every page-table entry is invalid, so any access to the logical region aborts until an entry is written.
- R2: A request presented in cycle N yields rsp_valid, rsp_grant, rsp_abort and rsp_addr in cycle N+1. rsp_valid is 0 in the cycle after a cycle with no request, and rsp_abort is never 1 without rsp_valid.
- R3: With req_user=1, a write to any address at or above 0x2000000 is refused (rsp_grant=0).
- R4: With req_user=1, a read in 0x2000000..0x37FFFFF is refused and a read at or above 0x3800000 is granted. A privileged access at or above 0x2000000 is always granted, with rsp_addr equal to req_addr.
- R5: A granted logical access returns rsp_addr = {4'b0, phys page, req_addr[14:0]}, where the table index is req_addr[21:15]. Bits 24:22 take no part, so the 4 MB window aliases across the region.
- R6: A logical access whose entry is invalid is refused. For a single transfer, rsp_abort is exactly the inverse of rsp_grant.
- R7: With the translation strobe low, any access to a valid logical page is granted, whatever its protection level.
- R8: Protection level 2'b00 grants reads and writes while the strobe is high.
- R9: Protection level 2'b01 grants reads, and grants writes only when os_mode=1, while the strobe is high.
- R10: Protection levels 2'b10 and 2'b11 refuse writes, and grant reads only when os_mode=1, while the strobe is high.
- R11: The strobe is req_user OR (req_post_idx AND req_wback) for a single transfer (req_block=0). For a block beat (req_block=1) it is req_user alone.
- R12: For each block beat, rsp_grant reports that beat's own decision. rsp_abort is 0 on non-final beats. On the final beat (req_last=1), rsp_abort is the OR of every refused beat since the block opened, including the final one.
- R13: A page-table write (pt_we=1) in cycle N governs requests from cycle N+1 on. A request in cycle N itself sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_mode | input | 1 | OS-mode bit from a control register |
| req_valid | input | 1 | Access request this cycle |
| req_addr | input | 26 | Byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_user | input | 1 | Processor is in user mode |
| req_post_idx | input | 1 | Single transfer is post-indexed |
| req_wback | input | 1 | Single transfer requests base write-back |
| req_block | input | 1 | Request is a beat of a block transfer |
| req_last | input | 1 | Final beat of a block transfer |
| pt_we | input | 1 | Page-table write strobe |
| pt_idx | input | 7 | Page-table entry to write |
| pt_valid | input | 1 | Valid bit for the entry |
| pt_phys | input | 7 | Physical page number |
| pt_prot | input | 2 | Protection level |
| rsp_valid | output | 1 | Decision valid |
| rsp_grant | output | 1 | Access may reach memory |
| rsp_abort | output | 1 | Abort to the processor |
| rsp_addr | output | 26 | Address for memory, meaningful when granted |

## Verification
Every decision lands exactly one clock after its request, and a table write changes only the decisions of requests that follow it. The bench therefore drives a request just after a falling edge. It computes the expected decision at once from its own model of the table, the sticky flag and the OS bit, and only then applies any table write in the same cycle to that model. It checks the response at the next falling edge. Block aborts are predicted only on the final beat's response, one cycle after that beat.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [1:0] {
        PROT_OPEN  = 2'b00,
        PROT_OSWR  = 2'b01,
        PROT_PRIVA = 2'b10,
        PROT_PRIVB = 2'b11
    } prot_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BLOCK = 1'b1
    } blk_state_e;

    // Whether a protection level lets an access through while the
    // translation strobe is high.
    function automatic logic prot_allows(input logic [1:0] lvl,
                                         input logic       wr,
                                         input logic       os);
        logic res;
        unique case (prot_e'(lvl))
            PROT_OPEN:  res = 1'b1;
            PROT_OSWR:  res = !wr || os;
            PROT_PRIVA,
            PROT_PRIVB: res = !wr && os;
            default:    res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/mpc_page_table.sv
module mpc_page_table #(
    parameter int IDX_W  = 7,
    parameter int PHYS_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [PHYS_W-1:0] wr_phys,
    input  logic [1:0]        wr_prot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [PHYS_W-1:0] rd_phys,
    output logic [1:0]        rd_prot
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0]  vld_q;
    logic [PHYS_W-1:0] phys_q [DEPTH];
    logic [1:0]        prot_q [DEPTH];

    // Valid bits are reset; payload is only meaningful when valid.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            phys_q[wr_idx] <= wr_phys;
            prot_q[wr_idx] <= wr_prot;
        end
    end

    // Read uses the pre-write contents, so a write lands for the next request.
    always_comb begin
        rd_valid = vld_q[rd_idx];
        rd_phys  = phys_q[rd_idx];
        rd_prot  = prot_q[rd_idx];
    end

endmodule

// File: rtl/mpc_perm_eval.sv
module mpc_perm_eval
    import mpc_pkg::*;
#(
    parameter int          ADDR_W        = 26,
    parameter int          PAGE_BITS     = 15,
    parameter int          PHYS_W        = 7,
    parameter int          LOG_SPAN_BITS = 25,
    parameter logic [25:0] IO_TOP        = 26'h380_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              user,
    input  logic              trans,
    input  logic              os,
    input  logic              ent_valid,
    input  logic [PHYS_W-1:0] ent_phys,
    input  logic [1:0]        ent_prot,
    output logic              ok,
    output logic [ADDR_W-1:0] xaddr
);
    localparam int PAD_W = ADDR_W - PHYS_W - PAGE_BITS;

    logic in_logical;
    logic in_io;

    always_comb begin
        in_logical = (addr >> LOG_SPAN_BITS) == '0;
        in_io      = !in_logical && (addr < ADDR_W'(IO_TOP));
    end

    always_comb begin
        ok    = 1'b1;
        xaddr = addr;
        if (in_logical) begin
            xaddr = {{PAD_W{1'b0}}, ent_phys, addr[PAGE_BITS-1:0]};
            if (!ent_valid) begin
                ok = 1'b0;
            end else if (trans) begin
                ok = prot_allows(ent_prot, write, os);
            end
        end else if (user) begin
            if (write || in_io) begin
                ok = 1'b0;
            end
        end
    end

endmodule

// File: rtl/mpc_block_fsm.sv
module mpc_block_fsm
    import mpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic beat,
    input  logic last,
    input  logic beat_ok,
    output logic blk_abort
);
    blk_state_e state_q, state_d;
    logic       sticky_q, sticky_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            sticky_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            sticky_q <= sticky_d;
        end
    end

    // Next state and sticky accumulation.
    always_comb begin
        state_d  = state_q;
        sticky_d = sticky_q;
        if (beat) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (last) begin
                        sticky_d = 1'b0;
                    end else begin
                        state_d  = ST_BLOCK;
                        sticky_d = !beat_ok;
                    end
                end
                ST_BLOCK: begin
                    if (last) begin
                        state_d  = ST_IDLE;
                        sticky_d = 1'b0;
                    end else begin
                        sticky_d = sticky_q || !beat_ok;
                    end
                end
                default: begin
                    state_d  = ST_IDLE;
                    sticky_d = 1'b0;
                end
            endcase
        end
    end

    // Abort report, only on a final beat.
    always_comb begin
        blk_abort = 1'b0;
        if (beat && last) begin
            unique case (state_q)
                ST_IDLE:  blk_abort = !beat_ok;
                ST_BLOCK: blk_abort = sticky_q || !beat_ok;
                default:  blk_abort = !beat_ok;
            endcase
        end
    end

endmodule

// File: rtl/mpc_top.sv
module mpc_top
    import mpc_pkg::*;
#(
    parameter int          ADDR_W        = 26,
    parameter int          PAGE_BITS     = 15,
    parameter int          IDX_W         = 7,
    parameter int          PHYS_W        = 7,
    parameter int          LOG_SPAN_BITS = 25,
    parameter logic [25:0] IO_TOP        = 26'h380_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_mode,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              req_post_idx,
    input  logic              req_wback,
    input  logic              req_block,
    input  logic              req_last,
    input  logic              pt_we,
    input  logic [IDX_W-1:0]  pt_idx,
    input  logic              pt_valid,
    input  logic [PHYS_W-1:0] pt_phys,
    input  logic [1:0]        pt_prot,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_abort,
    output logic [ADDR_W-1:0] rsp_addr
);
    logic              ent_valid;
    logic [PHYS_W-1:0] ent_phys;
    logic [1:0]        ent_prot;
    logic              trans;
    logic              ok;
    logic [ADDR_W-1:0] xaddr;
    logic              blk_abort;
    logic              abort_d;

    mpc_page_table #(
        .IDX_W  (IDX_W),
        .PHYS_W (PHYS_W)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (pt_we),
        .wr_idx   (pt_idx),
        .wr_valid (pt_valid),
        .wr_phys  (pt_phys),
        .wr_prot  (pt_prot),
        .rd_idx   (req_addr[PAGE_BITS +: IDX_W]),
        .rd_valid (ent_valid),
        .rd_phys  (ent_phys),
        .rd_prot  (ent_prot)
    );

    // Translation strobe: user mode always; for single transfers also a
    // post-indexed access with write-back requested.
    always_comb begin
        trans = req_user || (!req_block && req_post_idx && req_wback);
    end

    mpc_perm_eval #(
        .ADDR_W        (ADDR_W),
        .PAGE_BITS     (PAGE_BITS),
        .PHYS_W        (PHYS_W),
        .LOG_SPAN_BITS (LOG_SPAN_BITS),
        .IO_TOP        (IO_TOP)
    ) u_eval (
        .addr      (req_addr),
        .write     (req_write),
        .user      (req_user),
        .trans     (trans),
        .os        (os_mode),
        .ent_valid (ent_valid),
        .ent_phys  (ent_phys),
        .ent_prot  (ent_prot),
        .ok        (ok),
        .xaddr     (xaddr)
    );

    mpc_block_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .beat      (req_valid && req_block),
        .last      (req_last),
        .beat_ok   (ok),
        .blk_abort (blk_abort)
    );

    always_comb begin
        abort_d = req_block ? blk_abort : !ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_abort <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && ok;
            rsp_abort <= req_valid && abort_d;
            rsp_addr  <= xaddr;
        end
    end

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
    parameter int          ADDR_W        = 26,
    parameter int          LOG_SPAN_BITS = 25,
    parameter logic [25:0] IO_TOP        = 26'h380_0000
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_write,
    input logic              req_user,
    input logic              req_block,
    input logic              req_last,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic              rsp_abort,
    input logic [ADDR_W-1:0] rsp_addr
);
    localparam logic [ADDR_W-1:0] LOG_TOP = ADDR_W'(1) << LOG_SPAN_BITS;

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_NO_RESP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_ABORT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_abort |-> rsp_valid); // R2
    AST_USER_HIGH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_user && req_write && req_addr >= LOG_TOP) |=> !rsp_grant); // R3
    AST_USER_IO_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_user && !req_write && req_addr >= LOG_TOP
         && req_addr < ADDR_W'(IO_TOP)) |=> !rsp_grant); // R4
    AST_PRIV_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_user && req_addr >= LOG_TOP)
        |=> (rsp_grant && rsp_addr == $past(req_addr))); // R4
    AST_SINGLE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_block) |=> (rsp_grant != rsp_abort)); // R6
    AST_MIDBLOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_block && !req_last) |=> !rsp_abort); // R12

endmodule

bind mpc_top mpc_checker #(
    .ADDR_W        (ADDR_W),
    .LOG_SPAN_BITS (LOG_SPAN_BITS),
    .IO_TOP        (IO_TOP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_user  (req_user),
    .req_block (req_block),
    .req_last  (req_last),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_abort (rsp_abort),
    .rsp_addr  (rsp_addr)
);

// File: tb/sim_mpc_top.sv
module sim_mpc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        os_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic [25:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        req_post_idx = 1'b0;
    logic        req_wback = 1'b0;
    logic        req_block = 1'b0;
    logic        req_last = 1'b0;
    logic        pt_we = 1'b0;
    logic [6:0]  pt_idx = '0;
    logic        pt_valid = 1'b0;
    logic [6:0]  pt_phys = '0;
    logic [1:0]  pt_prot = '0;
    logic        rsp_valid, rsp_grant, rsp_abort;
    logic [25:0] rsp_addr;

    always #4 clk = ~clk;

    mpc_top u0 (
        .clk(clk), .rst(rst), .os_mode(os_mode),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_user(req_user), .req_post_idx(req_post_idx), .req_wback(req_wback),
        .req_block(req_block), .req_last(req_last),
        .pt_we(pt_we), .pt_idx(pt_idx), .pt_valid(pt_valid),
        .pt_phys(pt_phys), .pt_prot(pt_prot),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_abort(rsp_abort), .rsp_addr(rsp_addr)
    );

    int checks = 0;
    int failures = 0;

    // Reference model state
    bit m_vld [128];
    int m_phys [128];
    int m_prot [128];
    bit m_inblk = 0;
    bit m_sticky = 0;

    // Expectation for the response due at the next falling edge
    bit    e_valid = 0;
    bit    e_grant = 0;
    bit    e_abort = 0;
    int    e_addr = 0;
    string e_tag = "R1";

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit model_ok(input int a, input bit wr, input bit usr,
                                    input bit tr, input bit os);
        int idx;
        int lvl;
        if (a < 32'h200_0000) begin
            idx = (a / 32768) % 128;
            if (!m_vld[idx]) return 0;
            if (!tr) return 1;
            lvl = m_prot[idx];
            if (lvl == 0) return 1;
            if (lvl == 1) return wr ? os : 1;
            if (wr) return 0;
            return os;
        end
        if (!usr) return 1;
        if (wr) return 0;
        return a >= 32'h380_0000;
    endfunction

    // Compute the expectation from the inputs just driven, then apply any
    // table write to the model (it governs later requests only).
    task automatic predict(input string tag);
        bit tr;
        bit ok;
        int a;
        a = int'(req_addr);
        e_tag = tag;
        e_valid = req_valid;
        e_grant = 0;
        e_abort = 0;
        if (req_valid) begin
            tr = req_user || (!req_block && req_post_idx && req_wback);
            ok = model_ok(a, req_write, req_user, tr, os_mode);
            e_grant = ok;
            if (a < 32'h200_0000)
                e_addr = m_phys[(a / 32768) % 128] * 32768 + (a % 32768);
            else
                e_addr = a;
            if (req_block) begin
                if (req_last) begin
                    e_abort = (m_inblk && m_sticky) || !ok;
                    m_inblk = 0;
                    m_sticky = 0;
                end else begin
                    m_sticky = (m_inblk && m_sticky) || !ok;
                    m_inblk = 1;
                end
            end else begin
                e_abort = !ok;
            end
        end
        if (pt_we) begin
            m_vld[pt_idx] = pt_valid;
            m_phys[pt_idx] = int'(pt_phys);
            m_prot[pt_idx] = int'(pt_prot);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(e_tag, "rsp_valid", int'(rsp_valid), int'(e_valid));
        if (e_valid) begin
            chk(e_tag, "rsp_grant", int'(rsp_grant), int'(e_grant));
            chk(e_tag, "rsp_abort", int'(rsp_abort), int'(e_abort));
            if (e_grant) chk(e_tag, "rsp_addr", int'(rsp_addr), e_addr);
        end else begin
            chk(e_tag, "rsp_abort idle", int'(rsp_abort), 0);
        end
    endtask

    task automatic set_req(input int a, input bit wr, input bit usr, input bit post,
                           input bit wb, input bit blk, input bit last);
        req_valid = 1; req_addr = a[25:0]; req_write = wr; req_user = usr;
        req_post_idx = post; req_wback = wb; req_block = blk; req_last = last;
    endtask

    task automatic acc(input int a, input bit wr, input bit usr, input bit post,
                       input bit wb, input bit blk, input bit last, input string tag);
        tick();
        pt_we = 0;
        set_req(a, wr, usr, post, wb, blk, last);
        predict(tag);
    endtask

    task automatic ptw(input int idx, input bit v, input int ph, input int pr);
        tick();
        req_valid = 0;
        pt_we = 1; pt_idx = idx[6:0]; pt_valid = v; pt_phys = ph[6:0]; pt_prot = pr[1:0];
        predict("R13");
    endtask

    task automatic idle(input string tag);
        tick();
        req_valid = 0; pt_we = 0;
        predict(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin m_vld[i] = 0; m_phys[i] = 0; m_prot[i] = 0; end
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        chk("R1", "rsp_abort in reset", int'(rsp_abort), 0);
        rst = 0;
        e_valid = 0; e_tag = "R1";
        // R1 / R6: empty table aborts on logical access
        acc(32'h0002_8000, 0, 0, 0, 0, 0, 0, "R1");
        acc(32'h0000_0000, 1, 0, 0, 0, 0, 0, "R1");
        // Fill the table; entries with idx%8==7 stay invalid
        for (int i = 0; i < 128; i++)
            ptw(i, (i % 8) != 7, i ^ 8'h5a, i % 4);
        idle("R2");
        // R7..R11: every level, direction, OS bit and strobe source
        for (int lvl = 0; lvl < 4; lvl++)
            for (int os = 0; os < 2; os++)
                for (int wr = 0; wr < 2; wr++)
                    for (int src = 0; src < 5; src++) begin
                        bit usr, post, wb;
                        string tag;
                        usr = (src == 0); post = (src == 2 || src == 3); wb = (src == 2 || src == 4);
                        if (src == 0 || src == 2)
                            tag = (lvl == 0) ? "R8" : (lvl == 1) ? "R9" : "R10";
                        else
                            tag = "R7";
                        if (src >= 2) tag = {tag, "/R11"};
                        tick();
                        os_mode = os[0];
                        set_req(lvl * 32768 + 16'h1234 + src * 4, wr[0], usr, post, wb, 0, 0);
                        predict(tag);
                    end
        os_mode = 0;
        // R3 / R4: user-mode region rules, privileged pass-through
        acc(32'h200_0000, 1, 1, 0, 0, 0, 0, "R3");
        acc(32'h3FF_FFFC, 1, 1, 0, 0, 0, 0, "R3");
        acc(32'h200_0000, 0, 1, 0, 0, 0, 0, "R4");
        acc(32'h37F_FFFC, 0, 1, 0, 0, 0, 0, "R4");
        acc(32'h380_0000, 0, 1, 0, 0, 0, 0, "R4");
        acc(32'h3FF_FFFC, 0, 1, 0, 0, 0, 0, "R4");
        acc(32'h300_0010, 1, 0, 0, 0, 0, 0, "R4");
        acc(32'h250_0020, 0, 0, 1, 1, 0, 0, "R4");
        // R5: aliasing of bits 24:22 and translation
        acc(32'h1C4_8ABC, 0, 0, 0, 0, 0, 0, "R5");
        acc(32'h004_8ABC, 0, 0, 0, 0, 0, 0, "R5");
        acc(32'h1FF_FFFC, 0, 0, 0, 0, 0, 0, "R5");
        // R6: invalid entry (idx 7 and 15)
        acc(7 * 32768, 0, 0, 0, 0, 0, 0, "R6");
        acc(15 * 32768 + 4, 1, 1, 0, 0, 0, 0, "R6");
        // R13: write in the same cycle as an access to the same page
        acc(3 * 32768, 1, 1, 0, 0, 0, 0, "R13");
        tick();
        pt_we = 1; pt_idx = 3; pt_valid = 1; pt_phys = 7'h11; pt_prot = 2'b00;
        set_req(3 * 32768 + 8, 1, 1, 0, 0, 0, 0);
        predict("R13");
        acc(3 * 32768 + 12, 1, 1, 0, 0, 0, 0, "R13");
        // R12: user block with one refused beat in the middle
        acc(0,          1, 1, 0, 0, 1, 0, "R12");
        acc(2 * 32768,  1, 1, 0, 0, 1, 0, "R12");
        acc(4,          1, 1, 0, 0, 1, 0, "R12");
        acc(8,          1, 1, 0, 0, 1, 1, "R12");
        // R12: clean block after the sticky flag was reported
        acc(0,          0, 1, 0, 0, 1, 0, "R12");
        acc(4,          0, 1, 0, 0, 1, 1, "R12");
        // R11/R12: privileged block ignores post-index/write-back for strobe
        acc(2 * 32768,  1, 0, 1, 1, 1, 0, "R11");
        acc(6 * 32768,  1, 0, 1, 1, 1, 1, "R11");
        // R12: one-beat blocks, refused then granted
        acc(2 * 32768,  1, 1, 0, 0, 1, 1, "R12");
        acc(0,          1, 1, 0, 0, 1, 1, "R12");
        idle("R2");
        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int r, a;
            bit inblk_next;
            tick();
            r = int'($urandom_range(0, 99));
            pt_we = (r < 8);
            pt_idx = 7'($urandom_range(0, 127));
            pt_valid = ($urandom_range(0, 5) != 0);
            pt_phys = 7'($urandom_range(0, 127));
            pt_prot = 2'($urandom_range(0, 3));
            os_mode = $urandom_range(0, 1) == 1;
            case ($urandom_range(0, 3))
                0: a = int'($urandom_range(32'h380_0000, 32'h3FF_FFFF));
                1: a = int'($urandom_range(32'h200_0000, 32'h37F_FFFF));
                default: a = int'($urandom_range(0, 32'h1FF_FFFF));
            endcase
            inblk_next = ($urandom_range(0, 2) == 0) || m_inblk;
            set_req(a, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                    $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                    inblk_next, $urandom_range(0, 3) == 0);
            req_valid = (r >= 15);
            predict("R2");
        end
        idle("R2");
        tick();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule